// File: doc/BRIEF.md
# Protected Core Configuration Register

This block holds the 16-bit configuration word of a trigger-processing core. A host reaches it through a simple read strobe, write strobe and data bus. The word changes only while a separate access-mode input grants protected access, so a stray host cycle cannot reconfigure a running core. Two bits of the word carry a fixed core version. The other fields are decoded onto dedicated outputs: pre-trigger control, drift-tube input enable, wider-phi enable, halo delay code and bunch-crossing history control. Fields with a restricted value set keep their previous contents when a write carries an illegal code.

The block also passes a vector of one-bit trigger paths. Every path has one register stage. One configurable path, the halo trigger (the third path by default), adds extra latency that the halo delay code selects. A two-deep shift register feeds a tap multiplexer, so the delay can be changed on any cycle and the other paths are not disturbed.

Top module: `core_cfg_reg`

## Requirements
- R1: A write (`host_wr` high at a clock edge) updates the word only when `acc_mode` is high in that cycle; with `acc_mode` low the outputs and stored word are left unchanged.
- R2: Read data bits 11:10 always return the version code 2'b01 on a granted read, whatever value was written there.
- R3: Read data bits 15:12 and 3:2 always read zero; values written there are dropped.
- R4: Bits 9:8 are pre-trigger control on `cfg_pretrig`, reset value 2; a write of 1, 2 or 3 is stored, and a write of 0 leaves the previous value.
- R5: Bit 7 is the drift-tube enable (`cfg_dt_en`), bit 6 the wider-phi enable (`cfg_wide_phi`) and bits 5:4 the halo delay code (`cfg_halo_code`), all resetting to 0. A granted write updates these outputs at the same clock edge.
- R6: Bits 1:0 are bunch-crossing history control on `cfg_bx_hist`, reset value 2; a write of 0, 1 or 2 is stored, and a write of 3 leaves the previous value.
- R7: On path `HALO_PATH`, `trig_out` equals `trig_in` delayed by 1 + E cycles. E is 0, 0, 1 or 2 for halo delay codes 0, 1, 2 and 3.
- R8: Every other trigger path has a latency of exactly 1 cycle, whatever the halo delay code.
- R9: A read (`host_rd` high at an edge) loads `host_rdata` at that edge with the word as it stood before any write in the same cycle. If `acc_mode` is low, the read loads zero. Without a read, `host_rdata` holds its value.
- R10: Synchronous reset sets the fields to their defaults and clears `host_rdata`, `trig_out` and the delay stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_mode | input | 1 | Protected access grant |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered host read data |
| cfg_pretrig | output | 2 | Pre-trigger control field |
| cfg_dt_en | output | 1 | Drift-tube input enable |
| cfg_wide_phi | output | 1 | Wider-phi extrapolation enable |
| cfg_halo_code | output | 2 | Halo delay code |
| cfg_bx_hist | output | 2 | Bunch-crossing history control |
| trig_in | input | NPATH | Trigger inputs |
| trig_out | output | NPATH | Registered trigger outputs |

## Verification
Field outputs change at the same edge that accepts a granted write, so the bench checks them on the falling edge that follows. `host_rdata` is loaded at the edge that samples the read strobe and is checked half a cycle later. The 1024 low-bit write patterns are swept twice, once with access granted and once without, and a bench model of the legal-value rules predicts every field. In the trigger test the bench keeps a history of the values it drove. After edge n, non-halo paths must show the input applied at edge n, and the halo path must show the input applied at edge n minus the extra delay; each of the four codes gets its own stream.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

  localparam int WORD_W = 16;
  localparam logic [1:0] CORE_VERSION = 2'b01;
  localparam logic [1:0] PRE_DEFAULT  = 2'd2;
  localparam logic [1:0] BXH_DEFAULT  = 2'd2;

  typedef struct packed {
    logic [1:0] pretrig;
    logic       dt_en;
    logic       wide_phi;
    logic [1:0] halo_code;
    logic [1:0] bx_hist;
  } cfg_fields_t;

  function automatic logic pretrig_legal(input logic [1:0] v);
    return v != 2'd0;
  endfunction

  function automatic logic bxh_legal(input logic [1:0] v);
    return v != 2'd3;
  endfunction

  // code 0,1 -> 0 ; 2 -> 1 ; 3 -> 2
  function automatic logic [1:0] halo_extra(input logic [1:0] code);
    return (code == 2'd0) ? 2'd0 : code - 2'd1;
  endfunction

  function automatic logic [WORD_W-1:0] pack_word(input cfg_fields_t f);
    return {4'b0000, CORE_VERSION, f.pretrig, f.dt_en, f.wide_phi,
            f.halo_code, 2'b00, f.bx_hist};
  endfunction

endpackage

// File: rtl/cfg_field_store.sv
module cfg_field_store
  import cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  output cfg_fields_t       fields
);

  logic [1:0] new_pre;
  logic [1:0] new_bxh;

  always_comb begin
    new_pre = wdata[9:8];
    new_bxh = wdata[1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fields.pretrig   <= PRE_DEFAULT;
      fields.dt_en     <= 1'b0;
      fields.wide_phi  <= 1'b0;
      fields.halo_code <= 2'd0;
      fields.bx_hist   <= BXH_DEFAULT;
    end else if (wr_en) begin
      if (pretrig_legal(new_pre)) fields.pretrig <= new_pre;
      fields.dt_en     <= wdata[7];
      fields.wide_phi  <= wdata[6];
      fields.halo_code <= wdata[5:4];
      if (bxh_legal(new_bxh)) fields.bx_hist <= new_bxh;
    end
  end

endmodule

// File: rtl/cfg_readback.sv
module cfg_readback
  import cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic              granted,
  input  cfg_fields_t       fields,
  output logic [WORD_W-1:0] rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_req) begin
      rdata <= granted ? pack_word(fields) : '0;
    end
  end

endmodule

// File: rtl/halo_delay_line.sv
module halo_delay_line #(
  parameter int MAX_EXTRA = 2,
  localparam int SELW = (MAX_EXTRA < 1) ? 1 : $clog2(MAX_EXTRA + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            din,
  input  logic [SELW-1:0] sel,
  output logic            dout
);

  localparam logic [SELW-1:0] MAXSEL = SELW'(MAX_EXTRA);

  logic [MAX_EXTRA-1:0] sh;
  logic [MAX_EXTRA:0]   taps;

  for (genvar k = 0; k < MAX_EXTRA; k++) begin : g_stage
    if (k == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sh[0] <= 1'b0;
        else     sh[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sh[k] <= 1'b0;
        else     sh[k] <= sh[k-1];
      end
    end
  end

  assign taps = {sh, din};

  always_ff @(posedge clk) begin
    if (rst) dout <= 1'b0;
    else     dout <= (sel <= MAXSEL) ? taps[sel] : taps[MAXSEL];
  end

endmodule

// File: rtl/core_cfg_reg.sv
module core_cfg_reg
  import cfg_pkg::*;
#(
  parameter int NPATH     = 4,
  parameter int HALO_PATH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_mode,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  output logic [1:0]        cfg_pretrig,
  output logic              cfg_dt_en,
  output logic              cfg_wide_phi,
  output logic [1:0]        cfg_halo_code,
  output logic [1:0]        cfg_bx_hist,
  input  logic [NPATH-1:0]  trig_in,
  output logic [NPATH-1:0]  trig_out
);

  localparam int MAX_EXTRA = 2;
  localparam int SELW      = $clog2(MAX_EXTRA + 1);

  cfg_fields_t     fields;
  logic            wr_gated;
  logic [SELW-1:0] halo_sel;

  assign wr_gated = host_wr & acc_mode;
  assign halo_sel = SELW'(halo_extra(fields.halo_code));

  cfg_field_store u_store (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_gated),
    .wdata  (host_wdata),
    .fields (fields)
  );

  cfg_readback u_rb (
    .clk     (clk),
    .rst     (rst),
    .rd_req  (host_rd),
    .granted (acc_mode),
    .fields  (fields),
    .rdata   (host_rdata)
  );

  assign cfg_pretrig   = fields.pretrig;
  assign cfg_dt_en     = fields.dt_en;
  assign cfg_wide_phi  = fields.wide_phi;
  assign cfg_halo_code = fields.halo_code;
  assign cfg_bx_hist   = fields.bx_hist;

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    if (p == HALO_PATH) begin : g_halo
      halo_delay_line #(.MAX_EXTRA(MAX_EXTRA)) u_dly (
        .clk  (clk),
        .rst  (rst),
        .din  (trig_in[p]),
        .sel  (halo_sel),
        .dout (trig_out[p])
      );
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst) trig_out[p] <= 1'b0;
        else     trig_out[p] <= trig_in[p];
      end
    end
  end

endmodule

// File: rtl/core_cfg_reg_chk.sv
module core_cfg_reg_chk #(
  parameter int NPATH     = 4,
  parameter int HALO_PATH = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             acc_mode,
  input logic             host_wr,
  input logic             host_rd,
  input logic [15:0]      host_wdata,
  input logic [15:0]      host_rdata,
  input logic [1:0]       cfg_pretrig,
  input logic             cfg_dt_en,
  input logic             cfg_wide_phi,
  input logic [1:0]       cfg_halo_code,
  input logic [1:0]       cfg_bx_hist,
  input logic [NPATH-1:0] trig_in,
  input logic [NPATH-1:0] trig_out
);

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  localparam int OTHER = (HALO_PATH == 0) ? 1 : 0;

  p_locked_r1: assert property (@(posedge clk) disable iff (rst)
    (!acc_mode && since_rst != 2'd0) |=> ($stable(cfg_pretrig) && $stable(cfg_dt_en) &&
      $stable(cfg_wide_phi) && $stable(cfg_halo_code) && $stable(cfg_bx_hist)));

  p_version_r2: assert property (@(posedge clk) disable iff (rst)
    (host_rd && acc_mode) |=> (host_rdata[11:10] == 2'b01));

  p_unused_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (host_rdata[15:12] == 4'd0) && (host_rdata[3:2] == 2'd0));

  p_pre_legal_r4: assert property (@(posedge clk) disable iff (rst)
    cfg_pretrig != 2'd0);

  p_bxh_legal_r6: assert property (@(posedge clk) disable iff (rst)
    cfg_bx_hist != 2'd3);

  p_halo_max_r7: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && cfg_halo_code == 2'd3 && $past(cfg_halo_code) == 2'd3)
      |=> (trig_out[HALO_PATH] == $past(trig_in[HALO_PATH], 3)));

  p_plain_path_r8: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0) |=> (trig_out[OTHER] == $past(trig_in[OTHER])));

  p_read_lock_r9: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !acc_mode) |=> (host_rdata == 16'd0));

endmodule

bind core_cfg_reg core_cfg_reg_chk #(.NPATH(NPATH), .HALO_PATH(HALO_PATH)) u_chk (
  .clk(clk), .rst(rst), .acc_mode(acc_mode), .host_wr(host_wr), .host_rd(host_rd),
  .host_wdata(host_wdata), .host_rdata(host_rdata), .cfg_pretrig(cfg_pretrig),
  .cfg_dt_en(cfg_dt_en), .cfg_wide_phi(cfg_wide_phi), .cfg_halo_code(cfg_halo_code),
  .cfg_bx_hist(cfg_bx_hist), .trig_in(trig_in), .trig_out(trig_out)
);

// File: tb/sim_core_cfg_reg.sv
`timescale 1ns/1ps
module sim_core_cfg_reg;

  localparam int NPATH = 4;
  localparam int HP    = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_mode = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic [1:0]  cfg_pretrig, cfg_halo_code, cfg_bx_hist;
  logic        cfg_dt_en, cfg_wide_phi;
  logic [NPATH-1:0] trig_in = '0;
  logic [NPATH-1:0] trig_out;

  always #5 clk = ~clk;

  core_cfg_reg #(.NPATH(NPATH), .HALO_PATH(HP)) u0 (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  logic [1:0] e_pre = 2'd2, e_hc = 2'd0, e_bx = 2'd2;
  logic e_dt = 1'b0, e_wp = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word();
    return {4'b0, 2'b01, e_pre, e_dt, e_wp, e_hc, 2'b00, e_bx};
  endfunction

  task automatic model_write(input logic [15:0] d);
    if (d[9:8] != 2'd0) e_pre = d[9:8];
    e_dt = d[7];
    e_wp = d[6];
    e_hc = d[5:4];
    if (d[1:0] != 2'd3) e_bx = d[1:0];
  endtask

  task automatic do_write(input logic mode, input logic [15:0] d);
    acc_mode = mode; host_wr = 1'b1; host_wdata = d;
    @(posedge clk); @(negedge clk);
    host_wr = 1'b0; acc_mode = 1'b0;
  endtask

  task automatic do_read(input logic mode);
    acc_mode = mode; host_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    host_rd = 1'b0; acc_mode = 1'b0;
  endtask

  task automatic check_fields(input string tag);
    chk(cfg_pretrig == e_pre, {"R4 pretrig ", tag}, cfg_pretrig, e_pre);
    chk({cfg_dt_en, cfg_wide_phi, cfg_halo_code} == {e_dt, e_wp, e_hc},
        {"R5 dt/wphi/halo ", tag}, {cfg_dt_en, cfg_wide_phi, cfg_halo_code}, {e_dt, e_wp, e_hc});
    chk(cfg_bx_hist == e_bx, {"R6 bxhist ", tag}, cfg_bx_hist, e_bx);
  endtask

  task automatic check_readback(input string tag);
    do_read(1'b1);
    chk(host_rdata[11:10] == 2'b01, {"R2 version ", tag}, host_rdata[11:10], 2'b01);
    chk(host_rdata[15:12] == 4'd0 && host_rdata[3:2] == 2'd0, {"R3 unused ", tag},
        host_rdata, host_rdata & 16'h0FF3);
    chk(host_rdata == exp_word(), {"R9 word ", tag}, host_rdata, exp_word());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] lf;
    logic [NPATH-1:0] hist [0:63];
    int extra;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(host_rdata == 16'd0, "R10 rdata reset", host_rdata, 16'd0);
    chk(trig_out == '0, "R10 trig reset", trig_out, 0);
    check_fields("R10 reset");
    check_readback("R10 reset word");

    // R4 R5 R6 granted sweep of low ten bits, upper bits varied
    for (int i = 0; i < 1024; i++) begin
      logic [15:0] d;
      d = {i[5:0] ^ 6'h2A, i[9:0]};
      do_write(1'b1, d);
      model_write(d);
      check_fields("granted sweep");
      check_readback("granted sweep");
    end

    // R1 ignored writes without grant
    for (int i = 0; i < 1024; i++) begin
      logic [15:0] d;
      d = ~{i[5:0] ^ 6'h15, i[9:0]};
      do_write(1'b0, d);
      check_fields("R1 no grant");
      if (i % 64 == 0) begin
        check_readback("R1 no grant");
        do_read(1'b0);
        chk(host_rdata == 16'd0, "R9 read without grant", host_rdata, 16'd0);
      end
    end

    // R9 read and write in the same cycle returns the old word
    begin
      logic [15:0] old;
      old = exp_word();
      acc_mode = 1'b1; host_wr = 1'b1; host_rd = 1'b1; host_wdata = 16'h02A1 ^ old;
      @(posedge clk); @(negedge clk);
      host_wr = 1'b0; host_rd = 1'b0; acc_mode = 1'b0;
      model_write(16'h02A1 ^ old);
      chk(host_rdata == old, "R9 same-cycle read", host_rdata, old);
      @(posedge clk); @(negedge clk);
      chk(host_rdata == old, "R9 rdata held", host_rdata, old);
      check_fields("R9 same-cycle write");
    end

    // R7 R8 trigger latency per halo code
    lf = 8'h5B;
    for (int c = 0; c < 4; c++) begin
      logic [15:0] d;
      d = {6'd0, 2'd1, 2'b00, c[1:0], 4'b0001};
      do_write(1'b1, d);
      model_write(d);
      extra = (c == 0) ? 0 : c - 1;
      for (int n = 0; n < 64; n++) begin
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        trig_in = lf[NPATH-1:0];
        hist[n] = lf[NPATH-1:0];
        @(posedge clk); @(negedge clk);
        if (n >= 2) begin
          logic [NPATH-1:0] ex;
          ex = hist[n];
          ex[HP] = hist[n - extra][HP];
          chk(trig_out[HP] == ex[HP], "R7 halo latency", trig_out[HP], ex[HP]);
          chk((trig_out & ~(NPATH'(1) << HP)) == (ex & ~(NPATH'(1) << HP)),
              "R8 plain latency", trig_out, ex);
        end
      end
      trig_in = '0;
    end

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule